// File: doc/BRIEF.md
# Super-Tiled Pixel Address Mapper

This block turns a pixel coordinate into the byte address of that pixel in a framebuffer stored with a three-level tiled layout. A surface is described by one or two base addresses, its width counted in whole super-tiles, and a pixel size of 1, 2 or 4 bytes. Pixels form 4x4 tiles. Tiles form groups two tiles wide and four tiles tall. Groups form 64x64-pixel super-tiles, eight groups across and four down. Every level is stored row-major, and so are the super-tiles across the surface.

A split option places the even and odd 4x4 tiles in two separate memory regions. In split mode each region holds half the tiles, so its offsets are half as large. The block reports the region it picked next to the address. A request is a coordinate qualified by a valid strobe. The answer appears one clock later with its own valid. There is no backpressure, so a new coordinate can be given on every cycle.

Top module: `supertile_addr_map`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock. While reset is held, `out_valid`, `out_addr` and `out_region` are all 0.
- R2: Inside a 4x4 tile, the pixel position is (y mod 4)*4 + (x mod 4).
- R3: Inside a super-tile, the local pixel index is group*128 + tile*16 + pixel. Here group = ((y mod 64) div 16)*8 + (x mod 64) div 8, and tile = ((y div 4) mod 4)*2 + (x div 4) mod 2.
- R4: The super-tile index is (y div 64)*`surf_width` + (x div 64). The linear pixel index is that super-tile index * 4096 + the local index.
- R5: The pixel size comes from `bpp_code`: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Without split, `out_addr` = `surf_base0` + linear index * size, modulo 2^ADDR_W, and `out_region` = 0.
- R6: In split mode, `out_region` is the parity of the global tile index (linear index div 16). Region 1 addresses are built on `surf_base1` and region 0 addresses on `surf_base0`.
- R7: In split mode, the offset from the chosen base is ((tile index div 2)*16 + linear index mod 16) * size.
- R8: In a cycle with `in_valid` low, `out_addr` and `out_region` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coordinate strobe |
| in_x | input | X_W | Pixel column |
| in_y | input | Y_W | Pixel row |
| surf_base0 | input | ADDR_W | Base of region 0 (the only region without split) |
| surf_base1 | input | ADDR_W | Base of region 1 |
| surf_width | input | WST_W | Surface width in super-tiles |
| bpp_code | input | 2 | Pixel size code |
| split_en | input | 1 | Split layout enable |
| out_valid | output | 1 | Result strobe |
| out_addr | output | ADDR_W | Byte address |
| out_region | output | 1 | Region of the address |

## Verification
The assertions check on every cycle:
- the one-cycle valid delay;
- that the address and region hold during idle cycles;
- the region choice, which follows the coordinate's tile-column parity in split mode and is 0 otherwise;
- the 4x4 in-tile byte position for one-byte pixels;
- word alignment for four-byte pixels.

The full hierarchy cannot be checked that way: group and super-tile ordering, the multiply by surface width, the halved split offsets and address wrap at the top of the space. Those are shown only by the bench's scenarios, which compare every output against a behavioural model.

// File: rtl/supertile_map_pkg.sv
package supertile_map_pkg;
  localparam int TILE_LOG      = 2;                     // 4x4 pixel tile
  localparam int TILE_PIX_LOG  = 2 * TILE_LOG;          // 16 pixels
  localparam int GRP_TW_LOG    = 1;                     // group 2 tiles wide
  localparam int GRP_TH_LOG    = 2;                     // group 4 tiles tall
  localparam int ST_LOG        = 6;                     // 64x64 super-tile
  localparam int ST_PIX_LOG    = 2 * ST_LOG;            // 4096 pixels
  localparam int GRP_X_LOG     = ST_LOG - TILE_LOG - GRP_TW_LOG; // 8 groups across
  localparam int GRP_Y_LOG     = ST_LOG - TILE_LOG - GRP_TH_LOG; // 4 groups down

  typedef enum logic [1:0] {
    PIX_1B  = 2'd0,
    PIX_2B  = 2'd1,
    PIX_4B  = 2'd2,
    PIX_4BX = 2'd3
  } pix_size_e;
endpackage

// File: rtl/st_local_swizzle.sv
module st_local_swizzle
  import supertile_map_pkg::*;
(
  input  logic [ST_LOG-1:0]     lx,
  input  logic [ST_LOG-1:0]     ly,
  output logic [ST_PIX_LOG-1:0] local_idx
);
  logic [TILE_LOG-1:0]   pix_col, pix_row;
  logic [GRP_TW_LOG-1:0] tile_col;
  logic [GRP_TH_LOG-1:0] tile_row;
  logic [GRP_X_LOG-1:0]  grp_col;
  logic [GRP_Y_LOG-1:0]  grp_row;

  always_comb begin
    pix_col  = lx[TILE_LOG-1:0];
    pix_row  = ly[TILE_LOG-1:0];
    tile_col = lx[TILE_LOG +: GRP_TW_LOG];
    tile_row = ly[TILE_LOG +: GRP_TH_LOG];
    grp_col  = lx[TILE_LOG+GRP_TW_LOG +: GRP_X_LOG];
    grp_row  = ly[TILE_LOG+GRP_TH_LOG +: GRP_Y_LOG];
    // most significant: group row, group col, tile row, tile col, pixel row, pixel col
    local_idx = {grp_row, grp_col, tile_row, tile_col, pix_row, pix_col};
  end
endmodule

// File: rtl/st_surface_index.sv
module st_surface_index
  import supertile_map_pkg::*;
#(
  parameter int X_W   = 16,
  parameter int Y_W   = 16,
  parameter int WST_W = 8,
  localparam int ST_W  = Y_W - ST_LOG + WST_W + 1,
  localparam int IDX_W = ST_W + ST_PIX_LOG
)(
  input  logic [X_W-ST_LOG-1:0] st_col,
  input  logic [Y_W-ST_LOG-1:0] st_row,
  input  logic [WST_W-1:0]      width_st,
  input  logic [ST_PIX_LOG-1:0] local_idx,
  output logic [IDX_W-1:0]      lin_idx
);
  logic [ST_W-1:0] st_idx;

  always_comb begin
    st_idx  = ST_W'(st_row) * ST_W'(width_st) + ST_W'(st_col);
    lin_idx = {st_idx, local_idx};
  end
endmodule

// File: rtl/st_byte_offset.sv
module st_byte_offset
  import supertile_map_pkg::*;
#(
  parameter int IDX_W  = 31,
  parameter int ADDR_W = 32,
  localparam int OFF_W = IDX_W + 2
)(
  input  logic [IDX_W-1:0]  lin_idx,
  input  logic [1:0]        bpp_code,
  input  logic              split_en,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] base1,
  output logic [ADDR_W-1:0] addr,
  output logic              region
);
  logic [IDX_W-1:0] split_idx, pick_idx;
  logic [1:0]       sh;
  logic [OFF_W-1:0] off;

  always_comb begin
    // drop the tile parity bit: tile index halves, in-tile position stays
    split_idx = {1'b0, lin_idx[IDX_W-1:TILE_PIX_LOG+1], lin_idx[TILE_PIX_LOG-1:0]};
    region    = split_en & lin_idx[TILE_PIX_LOG];
    pick_idx  = split_en ? split_idx : lin_idx;
    unique case (pix_size_e'(bpp_code))
      PIX_1B:  sh = 2'd0;
      PIX_2B:  sh = 2'd1;
      default: sh = 2'd2;
    endcase
    off  = OFF_W'(pick_idx) << sh;
    addr = (region ? base1 : base0) + ADDR_W'(off);
  end
endmodule

// File: rtl/supertile_addr_map.sv
module supertile_addr_map
  import supertile_map_pkg::*;
#(
  parameter int X_W    = 16,
  parameter int Y_W    = 16,
  parameter int WST_W  = 8,
  parameter int ADDR_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [X_W-1:0]    in_x,
  input  logic [Y_W-1:0]    in_y,
  input  logic [ADDR_W-1:0] surf_base0,
  input  logic [ADDR_W-1:0] surf_base1,
  input  logic [WST_W-1:0]  surf_width,
  input  logic [1:0]        bpp_code,
  input  logic              split_en,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_region
);
  localparam int ST_W  = Y_W - ST_LOG + WST_W + 1;
  localparam int IDX_W = ST_W + ST_PIX_LOG;

  logic [ST_PIX_LOG-1:0] local_idx;
  logic [IDX_W-1:0]      lin_idx;
  logic [ADDR_W-1:0]     addr_d, addr_q;
  logic                  region_d, region_q, valid_q;
  logic [ADDR_W-1:0]     addr_nx;
  logic                  region_nx;
  logic                  load_en;

  st_local_swizzle u_swz (
    .lx        (in_x[ST_LOG-1:0]),
    .ly        (in_y[ST_LOG-1:0]),
    .local_idx (local_idx)
  );

  st_surface_index #(.X_W(X_W), .Y_W(Y_W), .WST_W(WST_W)) u_sidx (
    .st_col    (in_x[X_W-1:ST_LOG]),
    .st_row    (in_y[Y_W-1:ST_LOG]),
    .width_st  (surf_width),
    .local_idx (local_idx),
    .lin_idx   (lin_idx)
  );

  st_byte_offset #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_off (
    .lin_idx  (lin_idx),
    .bpp_code (bpp_code),
    .split_en (split_en),
    .base0    (surf_base0),
    .base1    (surf_base1),
    .addr     (addr_d),
    .region   (region_d)
  );

  // next-state
  always_comb begin
    load_en   = in_valid;
    addr_nx   = load_en ? addr_d   : addr_q;
    region_nx = load_en ? region_d : region_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      addr_q   <= '0;
      region_q <= 1'b0;
    end else begin
      valid_q  <= in_valid;
      addr_q   <= addr_nx;
      region_q <= region_nx;
    end
  end

  assign out_valid  = valid_q;
  assign out_addr   = addr_q;
  assign out_region = region_q;
endmodule

// File: rtl/supertile_addr_map_chk.sv
module supertile_addr_map_chk #(
  parameter int X_W    = 16,
  parameter int Y_W    = 16,
  parameter int ADDR_W = 32
)(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [X_W-1:0]    in_x,
  input logic [Y_W-1:0]    in_y,
  input logic [ADDR_W-1:0] surf_base0,
  input logic [1:0]        bpp_code,
  input logic              split_en,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_region
);
  logic [ADDR_W-1:0] base0_q;
  logic [ADDR_W-1:0] rel0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base0_q <= '0;
    else if (in_valid) base0_q <= surf_base0;
  end
  assign rel0 = out_addr - base0_q;

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_addr) && $stable(out_region)));

  p_region_nosplit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !split_en) |=> !out_region);

  p_region_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && split_en) |=> (out_region == $past(in_x[2])));

  p_in_tile_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !split_en && bpp_code == 2'd0) |=>
      (rel0[3:0] == {$past(in_y[1:0]), $past(in_x[1:0])}));

  p_word_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !split_en && bpp_code[1]) |=> (rel0[1:0] == 2'b00));
endmodule

bind supertile_addr_map supertile_addr_map_chk #(
  .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
  .surf_base0(surf_base0), .bpp_code(bpp_code), .split_en(split_en),
  .out_valid(out_valid), .out_addr(out_addr), .out_region(out_region)
);

// File: tb/supertile_addr_map_tb_top.sv
module supertile_addr_map_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_x = '0, in_y = '0;
  logic [31:0] surf_base0 = '0, surf_base1 = '0;
  logic [7:0]  surf_width = '0;
  logic [1:0]  bpp_code = '0;
  logic        split_en = 1'b0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_region;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_tag = "R1";

  longint unsigned exp_addr = 0;
  bit exp_valid = 0, exp_region = 0;

  always #10 clk = ~clk;

  supertile_addr_map dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .surf_base0(surf_base0), .surf_base1(surf_base1), .surf_width(surf_width),
    .bpp_code(bpp_code), .split_en(split_en),
    .out_valid(out_valid), .out_addr(out_addr), .out_region(out_region)
  );

  function automatic longint unsigned ref_lin(int x, int y, int w);
    int lx = x % 64, ly = y % 64;
    longint unsigned st  = longint'(y / 64) * w + x / 64;
    int grp = (ly / 16) * 8 + lx / 8;
    int tl  = ((ly / 4) % 4) * 2 + (lx / 4) % 2;
    int px  = (ly % 4) * 4 + lx % 4;
    return st * 4096 + grp * 128 + tl * 16 + px;
  endfunction

  // reference model, evaluated once per clock away from the active edge
  always @(negedge clk) begin
    longint unsigned lin, tile, off, base, nbytes;
    bit reg_sel;
    if (!rst_n) begin
      exp_valid = 0; exp_addr = 0; exp_region = 0;
    end else begin
      if (in_valid) begin
        lin    = ref_lin(int'(in_x), int'(in_y), int'(surf_width));
        nbytes = (bpp_code == 0) ? 1 : (bpp_code == 1) ? 2 : 4;
        tile   = lin / 16;
        if (split_en) begin
          reg_sel = tile[0];
          off  = ((tile / 2) * 16 + lin % 16) * nbytes;
        end else begin
          reg_sel = 0;
          off  = lin * nbytes;
        end
        base = reg_sel ? surf_base1 : surf_base0;
        exp_addr   = (base + off) & 64'hFFFF_FFFF;
        exp_region = reg_sel;
      end
      exp_valid = in_valid;
    end
    cycles++;
  end

  // compare on every clock, after the model has updated
  always @(negedge clk) begin
    #1;
    checks++;
    if (out_valid !== exp_valid) begin
      fails++;
      $display("FAIL R1 out_valid got %0b exp %0b", out_valid, exp_valid);
    end
    checks++;
    if (out_addr !== exp_addr[31:0]) begin
      fails++;
      $display("FAIL %s out_addr got %h exp %h", cur_tag, out_addr, exp_addr[31:0]);
    end
    checks++;
    if (out_region !== exp_region) begin
      fails++;
      $display("FAIL R6 out_region got %0b exp %0b", out_region, exp_region);
    end
  end

  task automatic drive(bit v, int x, int y, int w, int bpp, bit sp, string tag);
    @(negedge clk);
    #2;
    cur_tag    = tag;
    in_valid   = v;
    in_x       = 16'(x);
    in_y       = 16'(y);
    surf_width = 8'(w);
    bpp_code   = 2'(bpp);
    split_en   = sp;
  endtask

  initial begin
    logic [15:0] lfsr;
    // R1: reset values while held
    cur_tag = "R1";
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;
    surf_base0 = 32'h1000_0000;
    surf_base1 = 32'h2000_0000;

    // R1: valid pulse timing
    drive(1, 5, 6, 2, 0, 0, "R1");
    drive(0, 0, 0, 2, 0, 0, "R1");
    drive(1, 7, 3, 2, 0, 0, "R1");

    // R8: inputs change while idle, outputs must hold
    for (int i = 0; i < 6; i++) drive(0, 100 + i * 13, 77 + i, 3, i % 3, i[0], "R8");

    // R2: every pixel of one tile
    for (int y = 0; y < 4; y++)
      for (int x = 0; x < 4; x++) drive(1, 68 + x, 8 + y, 2, 0, 0, "R2");

    // R3: every tile origin within a super-tile, plus interior points
    for (int y = 0; y < 64; y += 4)
      for (int x = 0; x < 64; x += 4) drive(1, x + (y % 3), y + (x % 4), 1, 0, 0, "R3");

    // R4: super-tile ordering with several widths
    for (int w = 1; w < 5; w++)
      for (int k = 0; k < 8; k++) drive(1, (k * 61) % (w * 64), 63 + k * 37, w, 0, 0, "R4");
    drive(1, 16'hFFFF, 16'hFFFF, 255, 0, 0, "R4");

    // R5: pixel sizes, including the code that aliases to 4 bytes
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 6; k++) drive(1, 9 + k * 21, 130 + k * 11, 3, b, 0, "R5");
    // R5: address wrap at the top of the space
    surf_base0 = 32'hFFFF_F000;
    for (int k = 0; k < 4; k++) drive(1, 64 + k * 5, 64 + k * 3, 4, 2, 0, "R5");
    surf_base0 = 32'h1000_0000;

    // R6 and R7: split layout across tile columns and sizes
    for (int b = 0; b < 3; b++)
      for (int x = 0; x < 40; x++) drive(1, x, 21 + b * 17, 2, b, 1, "R7");
    for (int k = 0; k < 20; k++) drive(1, k * 29, k * 43, 5, 1, 1, "R6");

    // mixed traffic
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[3], int'(lfsr) * 7 % 700, int'(lfsr) % 500, 11,
            int'(lfsr[5:4]), lfsr[9], "R7");
    end

    drive(0, 0, 0, 1, 0, 0, "R8");
    repeat (3) @(negedge clk);
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog expired got %0d cycles exp < 150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule